// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

A register-mapped general-purpose I/O port of up to 16 pins. Each pin has a direction bit and an output data bit that drive the pad controls, and its input level is synchronised and readable. Each pin also feeds an interrupt detector. The detector's trigger is chosen per pin from falling edge, rising edge, low level, high level or both edges. Detected events latch into a sticky status bit. Software clears that bit with a write-1-to-clear strobe. A per-pin mask is changed through separate set and clear strobes, and a per-pin enable gates new events.

A flat 32-bit bus gives access to the registers. A write strobe, a byte address and write data make a write, and read data follows the address combinationally. One interrupt line is high while any pin has status that the mask does not hide. A software-reset register holds every other port register at its default while its bit 0 is 1. Writing it back to 0 releases the port.

Top module: `gpio_irq_port`

## Requirements
- R1: Registers are 32-bit words at these byte addresses: 0x00 enable, 0x04 status (read-only), 0x08 unmasked status (read-only), 0x0C status clear (write-only, reads 0), 0x10 mask set and 0x14 mask clear (both read back the mask), 0x18 output data, 0x1C input data (read-only), 0x20 direction, 0x24 mode for pins 0-7, 0x28 mode for pins 8-15, 0x2C software reset (bit 0). A write whose address has bits [1:0] non-zero is ignored.
- R2: `pins_oe_o` equals the direction register, where 1 means output. `pins_o` equals the output data register. Neither changes except through a write to its own register or through a reset.
- R3: The input data register returns `pins_i` through a two-stage synchroniser. A change made before clock edge k reads back after edge k+1.
- R4: Pin n has a 3-bit mode at bits [4n+2:4n] of the 0x24 register for n<8, and at bits [4(n-8)+2:4(n-8)] of the 0x28 register for n>=8. The codes are 000 falling, 001 rising, 010 low level, 011 high level, and 1xx both edges.
- R5: In an edge mode a qualifying pin change made before clock edge k sets status at edge k+2, and only once for each change.
- R6: In a level mode status is set on every cycle the active level is present, so a clear does not hold while the level persists.
- R7: A status bit is set only while its enable bit is 1. Clearing the enable stops new events and leaves existing status unchanged.
- R8: Writing 1 to a bit at 0x0C clears that status bit, and 0 bits leave status unchanged. If an event and a clear for the same pin fall in one cycle, the event wins.
- R9: A 1 written at 0x10 masks the pin and a 1 written at 0x14 unmasks it, while 0 bits leave the mask unchanged. The mask does not stop status being set. The register at 0x08 reads status AND NOT mask.
- R10: `irq_o` is 1 exactly when the 0x08 register is non-zero.
- R11: Register bits for pins at or above NUM_PINS, and bit 3 of every mode field, read 0 and ignore writes.
- R12: While the software-reset bit is 1, every other register and all status are held at 0, and writes to them are lost. The bit itself reads back, and writing 0 releases the port.
- R13: After `rst_ni` every register reads 0, so all pins are inputs with interrupts disabled and unmasked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pins_i | input | NUM_PINS | Pad input levels, asynchronous |
| pins_o | output | NUM_PINS | Output data to pads |
| pins_oe_o | output | NUM_PINS | Output enable per pin (1 = drive) |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong synchroniser depth or previous-value register shows as the status bit rising one cycle early or late. A directed test samples status on both sides of the expected edge to catch this. A wrong mode decode or field placement sets status on the wrong transition for one pin-and-mode pair. The sweep over all eight codes on every pin reads status after each rise, fall and clear, so such a fault shows within a few cycles of the bad transition. Faults in the mask or enable logic show on `irq_o` or in the 0x08 register on the next read.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  // word indices of the register map
  localparam int unsigned IDX_IEN   = 0;
  localparam int unsigned IDX_STAT  = 1;
  localparam int unsigned IDX_DISP  = 2;
  localparam int unsigned IDX_ICLR  = 3;
  localparam int unsigned IDX_MSET  = 4;
  localparam int unsigned IDX_MCLR  = 5;
  localparam int unsigned IDX_DOUT  = 6;
  localparam int unsigned IDX_DIN   = 7;
  localparam int unsigned IDX_DIR   = 8;
  localparam int unsigned IDX_MODE0 = 9;
  localparam int unsigned IDX_MODE1 = 10;
  localparam int unsigned IDX_SRST  = 11;

  localparam int unsigned MODE_W      = 3;
  localparam int unsigned FIELD_W     = 4;
  localparam int unsigned PINS_PER_MR = 8;

  // bit 2 of the mode selects both-edge detection, overriding these
  typedef enum logic [1:0] {
    DET_FALL = 2'b00,
    DET_RISE = 2'b01,
    DET_LOW  = 2'b10,
    DET_HIGH = 2'b11
  } det_kind_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_detect.sv
module gpio_pin_detect
  import gpio_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              level_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              en_i,
  input  logic              clr_i,
  input  logic              flush_i,
  output logic              status_o
);
  logic prev_q;
  logic hit;
  logic status_q;

  always_comb begin
    if (mode_i[2]) begin
      hit = prev_q ^ level_i;
    end else begin
      unique case (det_kind_e'(mode_i[1:0]))
        DET_FALL: hit = prev_q & ~level_i;
        DET_RISE: hit = ~prev_q & level_i;
        DET_LOW:  hit = ~level_i;
        DET_HIGH: hit = level_i;
        default:  hit = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= 1'b0;
      status_q <= 1'b0;
    end else begin
      prev_q <= level_i;
      if (flush_i)           status_q <= 1'b0;
      else if (en_i && hit)  status_q <= 1'b1;  // new event beats clear
      else if (clr_i)        status_q <= 1'b0;
    end
  end

  assign status_o = status_q;
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 16,
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pins_i,
  output logic [NUM_PINS-1:0] pins_o,
  output logic [NUM_PINS-1:0] pins_oe_o,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  output logic                irq_o
);
  localparam int unsigned W     = NUM_PINS;
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             aligned;
  logic             wr_ok;

  logic [W-1:0]             en_q, mask_q, dout_q, dir_q;
  logic [W-1:0][MODE_W-1:0] mode_q;
  logic                     srst_q;
  logic [W-1:0]             din_sync;
  logic [W-1:0]             status_w;
  logic [W-1:0]             clr_w;
  logic [W-1:0]             disp_w;
  logic [31:0]              mode0_rd, mode1_rd;

  assign idx     = addr_i[ADDR_W-1:2];
  assign aligned = (addr_i[1:0] == 2'b00);
  assign wr_ok   = wr_en_i && aligned;

  function automatic logic hit_idx(input logic [IDX_W-1:0] i, input int unsigned k);
    return i == IDX_W'(k);
  endfunction

  // software reset bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) srst_q <= 1'b0;
    else if (wr_ok && hit_idx(idx, IDX_SRST)) srst_q <= wdata_i[0];
  end

  // control registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      mask_q <= '0;
      dout_q <= '0;
      dir_q  <= '0;
      mode_q <= '0;
    end else if (srst_q) begin
      en_q   <= '0;
      mask_q <= '0;
      dout_q <= '0;
      dir_q  <= '0;
      mode_q <= '0;
    end else if (wr_ok) begin
      if (hit_idx(idx, IDX_IEN))  en_q   <= wdata_i[W-1:0];
      if (hit_idx(idx, IDX_MSET)) mask_q <= mask_q | wdata_i[W-1:0];
      if (hit_idx(idx, IDX_MCLR)) mask_q <= mask_q & ~wdata_i[W-1:0];
      if (hit_idx(idx, IDX_DOUT)) dout_q <= wdata_i[W-1:0];
      if (hit_idx(idx, IDX_DIR))  dir_q  <= wdata_i[W-1:0];
      for (int n = 0; n < int'(W); n++) begin
        if (n < int'(PINS_PER_MR) && hit_idx(idx, IDX_MODE0))
          mode_q[n] <= wdata_i[FIELD_W*(n % PINS_PER_MR) +: MODE_W];
        if (n >= int'(PINS_PER_MR) && hit_idx(idx, IDX_MODE1))
          mode_q[n] <= wdata_i[FIELD_W*(n % PINS_PER_MR) +: MODE_W];
      end
    end
  end

  gpio_sync #(
    .W      (W),
    .STAGES (SYNC_STAGES)
  ) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pins_i),
    .q_o    (din_sync)
  );

  assign clr_w = (wr_ok && hit_idx(idx, IDX_ICLR)) ? wdata_i[W-1:0] : '0;

  for (genvar p = 0; p < W; p++) begin : g_pin
    gpio_pin_detect i_det (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .level_i  (din_sync[p]),
      .mode_i   (mode_q[p]),
      .en_i     (en_q[p]),
      .clr_i    (clr_w[p]),
      .flush_i  (srst_q),
      .status_o (status_w[p])
    );
  end

  assign disp_w = status_w & ~mask_q;
  assign irq_o  = |disp_w;

  assign pins_o    = dout_q;
  assign pins_oe_o = dir_q;

  always_comb begin
    mode0_rd = '0;
    mode1_rd = '0;
    for (int n = 0; n < int'(W); n++) begin
      if (n < int'(PINS_PER_MR)) mode0_rd[FIELD_W*(n % PINS_PER_MR) +: MODE_W] = mode_q[n];
      else                       mode1_rd[FIELD_W*(n % PINS_PER_MR) +: MODE_W] = mode_q[n];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (aligned) begin
      unique case (int'(idx))
        IDX_IEN:   rdata_o = 32'(en_q);
        IDX_STAT:  rdata_o = 32'(status_w);
        IDX_DISP:  rdata_o = 32'(disp_w);
        IDX_MSET,
        IDX_MCLR:  rdata_o = 32'(mask_q);
        IDX_DOUT:  rdata_o = 32'(dout_q);
        IDX_DIN:   rdata_o = 32'(din_sync);
        IDX_DIR:   rdata_o = 32'(dir_q);
        IDX_MODE0: rdata_o = mode0_rd;
        IDX_MODE1: rdata_o = mode1_rd;
        IDX_SRST:  rdata_o = 32'(srst_q);
        default:   rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk #(
  parameter int unsigned NUM_PINS = 16,
  parameter int unsigned ADDR_W   = 6
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                wr_en_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [31:0]         wdata_i,
  input logic [31:0]         rdata_o,
  input logic [NUM_PINS-1:0] pins_o,
  input logic                irq_o,
  input logic                srst_i,
  input logic [NUM_PINS-1:0] en_i,
  input logic [NUM_PINS-1:0] mask_i,
  input logic [NUM_PINS-1:0] dir_i,
  input logic [NUM_PINS-1:0] status_i
);
  localparam logic [ADDR_W-1:0] A_MCLR = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] A_DOUT = ADDR_W'(8'h18);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(8'h24);

  p_status_needs_enable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i & ~$past(status_i) & ~$past(en_i)) == '0);

  p_mask_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_MCLR && !srst_i) |=> ((mask_i & $past(wdata_i[NUM_PINS-1:0])) == '0));

  p_dout_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(wr_en_i && addr_i == A_DOUT) && !srst_i) |=> $stable(pins_o));

  p_srst_clears_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> (en_i == '0 && mask_i == '0 && dir_i == '0 && status_i == '0));

  p_irq_needs_status_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (status_i != '0));

  p_upper_bits_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i < A_MODE) |-> ((rdata_o >> NUM_PINS) == 32'd0));
endmodule

bind gpio_irq_port gpio_irq_port_chk #(
  .NUM_PINS (NUM_PINS),
  .ADDR_W   (ADDR_W)
) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .pins_o   (pins_o),
  .irq_o    (irq_o),
  .srst_i   (srst_q),
  .en_i     (en_q),
  .mask_i   (mask_q),
  .dir_i    (dir_q),
  .status_i (status_w)
);

// File: tb/test_gpio_irq_port.sv
module test_gpio_irq_port;
  localparam int NP = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pins = '0;
  logic [NP-1:0] pins_out, pins_oe;
  logic          wr_en = 1'b0;
  logic [5:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  gpio_irq_port #(.NUM_PINS(NP)) i_gpio_irq_port (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .pins_i    (pins),
    .pins_o    (pins_out),
    .pins_oe_o (pins_oe),
    .wr_en_i   (wr_en),
    .addr_i    (addr),
    .wdata_i   (wdata),
    .rdata_o   (rdata),
    .irq_o     (irq)
  );

  localparam logic [5:0] A_IEN = 6'h00, A_STAT = 6'h04, A_DISP = 6'h08, A_ICLR = 6'h0C,
                         A_MSET = 6'h10, A_MCLR = 6'h14, A_DOUT = 6'h18, A_DIN = 6'h1C,
                         A_DIR = 6'h20, A_MODE0 = 6'h24, A_MODE1 = 6'h28, A_SRST = 6'h2C;
  localparam logic [31:0] ALL = 32'h0000_0FFF;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #0.5 d = rdata;
  endtask

  task automatic rd_now(input logic [5:0] a, output logic [31:0] d);
    addr = a;
    #0.5 d = rdata;
  endtask

  task automatic setpins(input logic [NP-1:0] v);
    @(negedge clk);
    pins = v;
  endtask

  task automatic cyc(input int k);
    repeat (k) @(posedge clk);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  function automatic logic [31:0] mode_word(input int pin, input int m, input bit hi);
    if (hi == (pin >= 8)) return 32'(m) << (4 * (pin % 8));
    return 32'd0;
  endfunction

  initial begin
    #400000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    logic [31:0] v, v2;
    cyc(3);
    @(negedge clk) rst_n = 1'b1;

    // R13: reset values
    for (int a = 0; a < 12; a++) begin
      rd(6'(a * 4), v);
      chk("R13 reset read", v, 32'd0);
    end
    chk("R13 irq after reset", 32'(irq), 32'd0);

    // R11: unimplemented bits, mode bit 3
    wr(A_IEN, 32'hFFFF_FFFF);
    rd(A_IEN, v);   chk("R11 enable width", v, ALL);
    wr(A_MODE0, 32'hFFFF_FFFF);
    rd(A_MODE0, v); chk("R11 mode0 bit3", v, 32'h7777_7777);
    wr(A_MODE1, 32'hFFFF_FFFF);
    rd(A_MODE1, v); chk("R11 mode1 pins>=NP", v, 32'h0000_7777);
    rd(A_ICLR, v);  chk("R1 clear reads 0", v, 32'd0);
    wr(A_IEN, 0); wr(A_MODE0, 0); wr(A_MODE1, 0);

    // R1: misaligned write ignored
    wr(6'h21, 32'h0000_0FFF);
    rd(A_DIR, v);   chk("R1 misaligned write", v, 32'd0);

    // R2: direction and output data
    wr(A_DIR, 32'h0000_0A5A);
    wr(A_DOUT, 32'h0000_00F0);
    @(negedge clk);
    chk("R2 oe", 32'(pins_oe), 32'h0A5A);
    chk("R2 out", 32'(pins_out), 32'h00F0);
    rd(A_DIR, v);  chk("R1 dir readback", v, 32'h0A5A);
    rd(A_DOUT, v); chk("R1 dout readback", v, 32'h00F0);
    wr(A_DIR, 0); wr(A_DOUT, 0);

    // R3/R5: synchroniser and edge timing on pin 0, rising mode
    wr(A_MODE0, 32'h1);
    wr(A_IEN, 32'h1);
    setpins(12'h001);
    cyc(1);
    rd_now(A_DIN, v); chk("R3 din after 1 edge", v, 32'd0);
    cyc(1);
    @(negedge clk);
    rd_now(A_DIN, v);  chk("R3 din after 2 edges", v, 32'h1);
    rd_now(A_STAT, v); chk("R5 status before edge k+2", v, 32'd0);
    cyc(1);
    @(negedge clk);
    rd_now(A_STAT, v); chk("R5 status at edge k+2", v, 32'h1);
    wr(A_ICLR, 32'h1);
    cyc(4);
    rd(A_STAT, v); chk("R5 single event per edge", v, 32'd0);
    setpins(0); cyc(4);
    wr(A_IEN, 0); wr(A_MODE0, 0); wr(A_ICLR, ALL);

    // R4/R5/R6: every code on every pin
    for (int p = 0; p < NP; p++) begin
      for (int m = 0; m < 8; m++) begin
        logic [31:0] b;
        bit fall, rise, low, high;
        b    = 32'd1 << p;
        fall = (m == 0) || (m >= 4);
        rise = (m == 1) || (m >= 4);
        low  = (m == 2);
        high = (m == 3);
        wr(A_IEN, 0);
        setpins(0); cyc(4);
        wr(A_ICLR, ALL);
        wr(A_MODE0, mode_word(p, m, 1'b0));
        wr(A_MODE1, mode_word(p, m, 1'b1));
        wr(A_IEN, b);
        cyc(4);
        rd(A_STAT, v); chk("R4 idle low", v, low ? b : 0);
        setpins(NP'(b)); cyc(4);
        rd(A_STAT, v); chk("R5 after rise", v, (rise || high || low) ? b : 0);
        wr(A_ICLR, ALL); cyc(4);
        rd(A_STAT, v); chk("R6 high held after clear", v, high ? b : 0);
        chk("R10 irq follows status", 32'(irq), high ? 1 : 0);
        setpins(0); cyc(4);
        rd(A_STAT, v); chk("R5 after fall", v, (fall || low || high) ? b : 0);
        wr(A_ICLR, ALL); cyc(4);
        rd(A_STAT, v); chk("R6 low held after clear", v, low ? b : 0);
      end
    end
    wr(A_IEN, 0); wr(A_MODE0, 0); wr(A_MODE1, 0); wr(A_ICLR, ALL);

    // R7: enable gating
    wr(A_MODE0, 32'h1);
    wr(A_IEN, 32'h1);
    setpins(12'h001); cyc(4);
    wr(A_IEN, 0);
    setpins(0); cyc(4);
    rd(A_STAT, v); chk("R7 status kept when disabled", v, 32'h1);
    wr(A_ICLR, 32'h1);
    setpins(12'h001); cyc(4);
    rd(A_STAT, v); chk("R7 no event when disabled", v, 32'd0);
    setpins(0); cyc(4);

    // R8: clear selectivity
    wr(A_MODE0, 32'h0001_1000);
    wr(A_IEN, 32'h18);
    setpins(12'h018); cyc(4);
    rd(A_STAT, v); chk("R8 two pins set", v, 32'h18);
    wr(A_ICLR, 32'h08);
    rd(A_STAT, v); chk("R8 clear one", v, 32'h10);
    wr(A_ICLR, 32'h00);
    rd(A_STAT, v); chk("R8 zero bits no effect", v, 32'h10);
    wr(A_ICLR, ALL);
    setpins(0); cyc(4);

    // R9/R10: masking on a held high level at pin 1
    wr(A_MODE0, 32'h30);
    wr(A_IEN, 32'h2);
    setpins(12'h002); cyc(4);
    chk("R10 irq unmasked", 32'(irq), 32'd1);
    wr(A_MSET, 32'h2);
    rd(A_DISP, v);  chk("R9 display masked", v, 32'd0);
    rd_now(A_STAT, v2); chk("R9 status kept under mask", v2, 32'h2);
    chk("R10 irq masked", 32'(irq), 32'd0);
    wr(A_MSET, 32'h0);
    rd(A_MSET, v);  chk("R9 mask set zero bits", v, 32'h2);
    wr(A_MCLR, 32'h0);
    rd(A_MCLR, v);  chk("R9 mask clear zero bits", v, 32'h2);
    wr(A_MCLR, 32'h2);
    rd(A_DISP, v);  chk("R9 display unmasked", v, 32'h2);
    chk("R10 irq restored", 32'(irq), 32'd1);
    setpins(0); cyc(4);

    // R12: software reset
    wr(A_DIR, 32'h0F);
    wr(A_DOUT, 32'h05);
    wr(A_MSET, 32'h3);
    wr(A_SRST, 32'h1);
    cyc(1);
    rd(A_SRST, v); chk("R12 srst readback", v, 32'h1);
    rd(A_IEN, v);  chk("R12 enable cleared", v, 32'd0);
    rd(A_MSET, v); chk("R12 mask cleared", v, 32'd0);
    rd(A_STAT, v); chk("R12 status cleared", v, 32'd0);
    chk("R12 oe cleared", 32'(pins_oe), 32'd0);
    wr(A_DIR, 32'h0F);
    rd(A_DIR, v);  chk("R12 write held off", v, 32'd0);
    wr(A_SRST, 32'h0);
    wr(A_DIR, 32'h0F);
    rd(A_DIR, v);  chk("R12 released", v, 32'h0F);

    summary();
  end
endmodule